// File: doc/BRIEF.md
# Input-order-sensitive both-low detector

This block watches two level signals, `sig_a` and `sig_b`, which are already synchronised to its clock. It raises `both_low_ok` while both signals are low, but only when `sig_a` went low at a time when `sig_b` was still high. If `sig_b` went low first, or both fell in the same sample, the output stays low for as long as both remain low. The surrounding logic is expected to change at most one input per sample.

The block has four named states:

| State | Meaning |
|-------|---------|
| `ST_IDLE` | `sig_a` is high. No order has been recorded. |
| `ST_ARMED` | `sig_a` is low and `sig_b` is high, so the order is good. |
| `ST_HIT` | Both inputs are low after a good order. The output is high. |
| `ST_MISS` | Both inputs are low, but the order was wrong or both fell together. |

The transitions apply on every clock edge and depend on the sampled inputs and the current state:

- Any state goes to `ST_IDLE` when `sig_a` is high.
- Any state goes to `ST_ARMED` when `sig_a` is low and `sig_b` is high.
- `ST_ARMED` or `ST_HIT` goes to `ST_HIT` when both inputs are low.
- `ST_IDLE` or `ST_MISS` goes to `ST_MISS` when both inputs are low.

Reset selects `ST_IDLE`. The output is a flop that is loaded from the next state at the same edge as the state register. It therefore reflects the inputs sampled at the previous rising edge.

Top module: `order_low_detect`

## Requirements
- R1: While `rst` is high at a rising edge, `both_low_ok` is 0 after that edge. After reset no order is recorded, so inputs that are both low from reset onward keep `both_low_ok` at 0.
- R2: `both_low_ok` is 1 after an edge only if both `sig_a` and `sig_b` were sampled low at that edge.
- R3: If `sig_a` is sampled low with `sig_b` high, and at a later edge both are sampled low, then `both_low_ok` is 1 after that later edge, with exactly one register of latency.
- R4: If `sig_b` falls first and `sig_a` falls afterwards, `both_low_ok` stays 0 for as long as both stay low.
- R5: A sample with `sig_a` high, or with `sig_b` high, gives `both_low_ok` = 0 after that edge. The order is then judged again from the new levels.
- R6: If both inputs go from high to low between two consecutive samples, `both_low_ok` stays 0 while both stay low.
- R7: Once `both_low_ok` is 1, it stays 1 for every further edge at which both inputs are sampled low.
- R8: If `sig_b` rises and falls again while `sig_a` stays low, `both_low_ok` returns to 1, because `sig_a` is again low before `sig_b` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| sig_a | input | 1 | First watched level, synchronous to `clk` |
| sig_b | input | 1 | Second watched level, synchronous to `clk` |
| both_low_ok | output | 1 | High while both inputs are low after `sig_a` fell first |

## Verification
The block has no parameters, so the bench builds it exactly as it is elaborated by default, and all four states and every transition between them are reachable.

Directed sequences cover each ordering case:
- a good fall order,
- a reversed fall order,
- a simultaneous fall,
- re-arming through a pulse on `sig_b`,
- release through either input.

A long walk that changes one input per step then compares the output against a behavioural order model on every clock. That walk also reaches reset-adjacent patterns and long holds in `ST_HIT` and `ST_MISS`.

// File: rtl/order_low_pkg.sv
package order_low_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_HIT   = 2'd2,
        ST_MISS  = 2'd3
    } olw_state_t;

endpackage

// File: rtl/order_low_next.sv
module order_low_next
    import order_low_pkg::*;
(
    input  olw_state_t cur_state,
    input  logic       sig_a,
    input  logic       sig_b,
    output olw_state_t nxt_state
);

    always_comb begin
        if (sig_a) begin
            // first input high: nothing recorded
            nxt_state = ST_IDLE;
        end else if (sig_b) begin
            // first input low, second still high: order good so far
            nxt_state = ST_ARMED;
        end else begin
            // both low: outcome depends on how we got here
            unique case (cur_state)
                ST_ARMED: nxt_state = ST_HIT;
                ST_HIT:   nxt_state = ST_HIT;
                ST_IDLE:  nxt_state = ST_MISS;
                ST_MISS:  nxt_state = ST_MISS;
                default:  nxt_state = ST_MISS;
            endcase
        end
    end

endmodule

// File: rtl/order_low_decode.sv
module order_low_decode
    import order_low_pkg::*;
(
    input  olw_state_t state_in,
    output logic       flag_out
);

    always_comb begin
        unique case (state_in)
            ST_HIT:   flag_out = 1'b1;
            ST_IDLE:  flag_out = 1'b0;
            ST_ARMED: flag_out = 1'b0;
            ST_MISS:  flag_out = 1'b0;
            default:  flag_out = 1'b0;
        endcase
    end

endmodule

// File: rtl/order_low_detect.sv
module order_low_detect
    import order_low_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sig_a,
    input  logic sig_b,
    output logic both_low_ok
);

    olw_state_t state_q;
    olw_state_t state_d;
    logic       flag_d;

    order_low_next u_next (
        .cur_state (state_q),
        .sig_a     (sig_a),
        .sig_b     (sig_b),
        .nxt_state (state_d)
    );

    order_low_decode u_decode (
        .state_in (state_d),
        .flag_out (flag_d)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // registered Moore output, loaded together with the state
    always_ff @(posedge clk) begin
        if (rst) begin
            both_low_ok <= 1'b0;
        end else begin
            both_low_ok <= flag_d;
        end
    end

endmodule

// File: rtl/order_low_chk.sv
module order_low_chk (
    input logic clk,
    input logic rst,
    input logic sig_a,
    input logic sig_b,
    input logic both_low_ok
);

    // R1
    reset_clears_chk: assert property (@(posedge clk) rst |=> !both_low_ok);

    // R2
    needs_both_low_chk: assert property (@(posedge clk) disable iff (rst)
        both_low_ok |-> ($past(!sig_a) && $past(!sig_b)));

    // R3
    rise_after_order_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(both_low_ok) |-> ($past(sig_b, 2) && !$past(sig_a, 2)));

    // R5
    release_a_chk: assert property (@(posedge clk) disable iff (rst)
        sig_a |=> !both_low_ok);

    // R5
    release_b_chk: assert property (@(posedge clk) disable iff (rst)
        sig_b |=> !both_low_ok);

    // R6
    joint_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (!sig_a && !sig_b && $past(sig_a) && $past(sig_b)) |=> !both_low_ok);

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (both_low_ok && !sig_a && !sig_b) |=> both_low_ok);

endmodule

bind order_low_detect order_low_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .sig_a       (sig_a),
    .sig_b       (sig_b),
    .both_low_ok (both_low_ok)
);

// File: tb/order_low_detect_test.sv
`timescale 1ns/1ps
module order_low_detect_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sig_a = 1'b1;
    logic sig_b = 1'b1;
    logic both_low_ok;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // model: "sig_a went low while sig_b was high, and sig_a stayed low since"
    bit good_order = 0;
    bit exp_z = 0;

    always #5 clk = ~clk;

    order_low_detect uut (
        .clk         (clk),
        .rst         (rst),
        .sig_a       (sig_a),
        .sig_b       (sig_b),
        .both_low_ok (both_low_ok)
    );

    task automatic check(input string req);
        checks++;
        if (both_low_ok !== exp_z) begin
            errors++;
            $display("FAIL %s: both_low_ok=%b expected=%b (a=%b b=%b)",
                     req, both_low_ok, exp_z, sig_a, sig_b);
        end
    endtask

    // apply levels, update model, advance one edge, check away from the edge
    task automatic step(input logic a, input logic b, input string req);
        sig_a = a;
        sig_b = b;
        exp_z      = !a && !b && good_order;
        good_order = !a && (good_order || b);
        @(posedge clk);
        @(negedge clk);
        check(req);
    endtask

    task automatic do_reset(input logic a, input logic b);
        rst = 1'b1;
        sig_a = a;
        sig_b = b;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        good_order = 0;
        exp_z = 0;
        check("R1");
        rst = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        do_reset(1'b0, 1'b0);
        // R1: both low from reset has no order
        step(0, 0, "R1");
        step(0, 0, "R1");

        // R3: a falls first, then b
        step(1, 1, "R5");
        step(0, 1, "R3");
        step(0, 0, "R3");
        // R7: hold
        step(0, 0, "R7");
        step(0, 0, "R7");
        // R8: b pulses while a low
        step(0, 1, "R8");
        step(0, 0, "R8");
        // R5: release through a
        step(1, 0, "R5");
        // R4: b fell first (already low), now a falls
        step(0, 0, "R4");
        step(0, 0, "R4");
        // R5: release through b, then re-arm
        step(0, 1, "R5");
        step(0, 0, "R3");
        step(0, 1, "R5");
        // R6: joint fall
        step(1, 1, "R2");
        step(0, 0, "R6");
        step(0, 0, "R6");
        // R4: b then a
        step(1, 1, "R2");
        step(1, 0, "R4");
        step(0, 0, "R4");
        // R1: reset in the middle of a hit
        step(1, 1, "R2");
        step(0, 1, "R3");
        step(0, 0, "R3");
        do_reset(1'b0, 1'b0);
        step(0, 0, "R1");

        // single-change walk checked on every clock
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 2) == 0) begin
                step(sig_a, sig_b, "R7");
            end else if ($urandom_range(0, 1) == 0) begin
                step(~sig_a, sig_b, "R2");
            end else begin
                step(sig_a, ~sig_b, "R3");
            end
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule